// File: doc/BRIEF.md
# Task and Configuration Prefetch Scheduler

This block dispatches a small acyclic task graph onto a pool of single-context reconfigurable units. It holds the run-time progress of every task (bound to a unit, started, finished) and reads a static task table: a predecessor mask, a configuration type and a fixed priority per task. On each cycle it may bind one task to an idle unit, and may launch one loaded task. A bound task either receives a reconfigure command or, when the idle unit already holds its configuration type, goes straight to the loaded state with no command.

Each task has two readiness conditions. It may be bound to a unit, and have its configuration loaded, once every predecessor has started. It may be launched only once every predecessor has finished. This lets a configuration load on one unit overlap the execution on another. The graph is run once per data block. A block begins with an iteration-start pulse and ends when every task has finished. At that point a one-cycle done flag is raised and the per-task progress is cleared. No binding is made for the next block until the next start pulse arrives. Units keep their loaded configuration across blocks.

Top module: `cfg_prefetch_sched`

## Requirements
- R1: After reset no command is issued, `iter_active_o` and `iter_done_o` are low, and no unit holds a valid configuration, so the first binding of every type needs a reconfigure command.
- R2: No command is issued while no iteration is active. A start pulse while idle opens an iteration on the next cycle. A start pulse during an active iteration has no effect.
- R3: A task may be bound only if it is not yet bound in this iteration and every predecessor has started. Bit j of task i's field (`task_pred_i[i*NT+j]`) set means task j precedes task i.
- R4: Among bindable tasks the one with the largest priority value wins. Ties go to the lowest task index.
- R5: The chosen task is bound to an idle unit (empty or finished). Idle units already holding its type are preferred: the lowest-index such unit is taken with no reconfigure command. Otherwise the lowest-index idle unit receives a reconfigure command (`cfg_valid_o`, unit, task). With no idle unit, nothing is bound.
- R6: A configuring unit becomes loaded on its `cfg_done_i` bit. Several units may configure at once, and configuring overlaps other units' execution.
- R7: A loaded unit is launched (`exe_valid_o`, unit, task) only when all predecessors of its task have finished. At most one launch occurs per cycle. Among ready units the largest task priority wins, with ties going to the lowest unit index.
- R8: A running unit's `exec_done_i` bit marks its task finished and makes the unit idle, keeping its configuration.
- R9: When all tasks of an active iteration have finished, `iter_done_o` is high for exactly that cycle. On the next cycle the iteration is closed and all progress is cleared.
- R10: A `cfg_done_i` bit for a unit that is not configuring, or an `exec_done_i` bit for a unit that is not running, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iter_start_i | input | 1 | Opens a graph iteration when idle |
| task_pred_i | input | NT*NT | Predecessor masks, NT bits per task |
| task_type_i | input | NT*TYPE_W | Configuration type per task |
| task_prio_i | input | NT*PRIO_W | Static priority per task, larger wins |
| cfg_done_i | input | NU | Per-unit configuration-complete event |
| exec_done_i | input | NU | Per-unit execution-complete event |
| cfg_valid_o | output | 1 | Reconfigure command this cycle |
| cfg_unit_o | output | UNIT_W | Unit to reconfigure |
| cfg_task_o | output | TASK_W | Task whose configuration to load |
| exe_valid_o | output | 1 | Execute command this cycle |
| exe_unit_o | output | UNIT_W | Unit to start |
| exe_task_o | output | TASK_W | Task being started |
| iter_active_o | output | 1 | An iteration is in progress |
| iter_done_o | output | 1 | All tasks of the iteration finished |

## Verification
The bench sweeps eight generated graphs, with shared types, priority ties and chains, through two iterations each. A cycle-level model predicts every command. The second iteration checks configuration reuse. A design that ignored held types would issue needless reconfigure commands, and one that skipped the type compare would launch a task on a unit holding the wrong configuration. Completion events arrive with varied delays, so several units configure together. A scheduler that waited for predecessors to finish before binding would issue its reconfigure commands late, while one that launched on started predecessors would run tasks early. Stray completion events and start pulses in mid-iteration are injected. A design that honoured them would skip states or reopen iterations, and one that leaked bindings across blocks would issue commands before the next start pulse.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [2:0] {
    U_EMPTY  = 3'd0,
    U_CFG    = 3'd1,
    U_LOADED = 3'd2,
    U_RUN    = 3'd3,
    U_FREE   = 3'd4
  } unit_st_e;

  function automatic logic unit_idle(input unit_st_e st);
    return (st == U_EMPTY) || (st == U_FREE);
  endfunction
endpackage

// File: rtl/pfs_prio_pick.sv
module pfs_prio_pick #(
  parameter int N      = 4,
  parameter int PRIO_W = 3,
  localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req_i,
  input  logic [N*PRIO_W-1:0] prio_i,
  output logic            valid_o,
  output logic [IW-1:0]   idx_o
);
  logic [PRIO_W-1:0] best_p;

  // Larger value wins; strict compare keeps the lowest index on ties.
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    best_p  = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && (!valid_o || prio_i[i*PRIO_W +: PRIO_W] > best_p)) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
        best_p  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end

  AST_PICK_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> req_i[idx_o]); // R4
  AST_PICK_NONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (req_i == '0)); // R4
endmodule

// File: rtl/pfs_unit_slot.sv
module pfs_unit_slot
  import pfs_pkg::*;
#(
  parameter int TASK_W = 3,
  parameter int TYPE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              assign_cfg_i,
  input  logic              assign_skip_i,
  input  logic [TASK_W-1:0] assign_task_i,
  input  logic [TYPE_W-1:0] assign_type_i,
  input  logic              launch_i,
  input  logic              cfg_done_i,
  input  logic              exec_done_i,
  output unit_st_e          state_o,
  output logic [TASK_W-1:0] task_o,
  output logic [TYPE_W-1:0] type_o,
  output logic              type_ok_o
);
  unit_st_e          st_q;
  logic [TASK_W-1:0] tsk_q;
  logic [TYPE_W-1:0] typ_q;
  logic              tok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= U_EMPTY;
      tsk_q <= '0;
      typ_q <= '0;
      tok_q <= 1'b0;
    end else if (assign_cfg_i) begin
      st_q  <= U_CFG;
      tsk_q <= assign_task_i;
      typ_q <= assign_type_i;
      tok_q <= 1'b0;
    end else if (assign_skip_i) begin
      st_q  <= U_LOADED;
      tsk_q <= assign_task_i;
    end else if (launch_i) begin
      st_q  <= U_RUN;
    end else if (st_q == U_CFG && cfg_done_i) begin
      st_q  <= U_LOADED;
      tok_q <= 1'b1;
    end else if (st_q == U_RUN && exec_done_i) begin
      st_q  <= U_FREE;
    end
  end

  assign state_o   = st_q;
  assign task_o    = tsk_q;
  assign type_o    = typ_q;
  assign type_ok_o = tok_q;

  AST_BIND_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (assign_cfg_i || assign_skip_i) |-> unit_idle(st_q)); // R5
  AST_SKIP_NEEDS_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    assign_skip_i |-> (tok_q && typ_q == assign_type_i)); // R5
  AST_LAUNCH_ON_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i |-> (st_q == U_LOADED)); // R7
  AST_CFG_DONE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == U_CFG && cfg_done_i) |=> (st_q == U_LOADED && tok_q)); // R6
  AST_RUN_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == U_RUN && exec_done_i) |=> (st_q == U_FREE)); // R8
  AST_STRAY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_idle(st_q) && !assign_cfg_i && !assign_skip_i) |=> (st_q == $past(st_q))); // R10
endmodule

// File: rtl/pfs_task_state.sv
module pfs_task_state #(
  parameter int NT     = 6,
  parameter int TASK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iter_start_i,
  input  logic              bind_valid_i,
  input  logic [TASK_W-1:0] bind_task_i,
  input  logic              launch_valid_i,
  input  logic [TASK_W-1:0] launch_task_i,
  input  logic [NT-1:0]     fin_mask_i,
  output logic [NT-1:0]     bound_o,
  output logic [NT-1:0]     started_o,
  output logic [NT-1:0]     finished_o,
  output logic              active_o,
  output logic              done_o
);
  logic [NT-1:0] bound_q, started_q, finished_q;
  logic          active_q;

  assign done_o = active_q && (&finished_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bound_q    <= '0;
      started_q  <= '0;
      finished_q <= '0;
      active_q   <= 1'b0;
    end else if (done_o) begin
      bound_q    <= '0;
      started_q  <= '0;
      finished_q <= '0;
      active_q   <= 1'b0;
    end else begin
      if (!active_q && iter_start_i) active_q <= 1'b1;
      if (bind_valid_i)   bound_q[bind_task_i]     <= 1'b1;
      if (launch_valid_i) started_q[launch_task_i] <= 1'b1;
      finished_q <= finished_q | fin_mask_i;
    end
  end

  assign bound_o    = bound_q;
  assign started_o  = started_q;
  assign finished_o = finished_q;
  assign active_o   = active_q;

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!active_q && finished_q == '0 && bound_q == '0)); // R9
  AST_OPEN_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> $past(iter_start_i)); // R2
  AST_NO_REBIND: assert property (@(posedge clk) disable iff (!rst_n)
    bind_valid_i |-> !bound_q[bind_task_i]); // R3
endmodule

// File: rtl/cfg_prefetch_sched.sv
module cfg_prefetch_sched
  import pfs_pkg::*;
#(
  parameter int NT     = 6,
  parameter int NU     = 3,
  parameter int TYPE_W = 2,
  parameter int PRIO_W = 3,
  localparam int TASK_W = (NT > 1) ? $clog2(NT) : 1,
  localparam int UNIT_W = (NU > 1) ? $clog2(NU) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 iter_start_i,
  input  logic [NT*NT-1:0]     task_pred_i,
  input  logic [NT*TYPE_W-1:0] task_type_i,
  input  logic [NT*PRIO_W-1:0] task_prio_i,
  input  logic [NU-1:0]        cfg_done_i,
  input  logic [NU-1:0]        exec_done_i,
  output logic                 cfg_valid_o,
  output logic [UNIT_W-1:0]    cfg_unit_o,
  output logic [TASK_W-1:0]    cfg_task_o,
  output logic                 exe_valid_o,
  output logic [UNIT_W-1:0]    exe_unit_o,
  output logic [TASK_W-1:0]    exe_task_o,
  output logic                 iter_active_o,
  output logic                 iter_done_o
);
  function automatic logic preds_met(input logic [NT-1:0] need, input logic [NT-1:0] have);
    return ~|(need & ~have);
  endfunction

  // Task progress
  logic [NT-1:0] bound_q, started_q, finished_q, fin_mask;
  logic          active_q, all_done;

  // Unit views
  unit_st_e          ust   [NU];
  logic [TASK_W-1:0] utask [NU];
  logic [TYPE_W-1:0] utype [NU];
  logic [NU-1:0]     utok;
  logic [NU-1:0]     bind_cfg, bind_skip, launch;

  // Prefetch selection
  logic [NT-1:0]     pf_req;
  logic              pf_valid;
  logic [TASK_W-1:0] pf_task;
  logic [TYPE_W-1:0] pf_type;
  logic              skip_hit, free_hit, do_skip, do_cfg;
  logic [UNIT_W-1:0] skip_unit, free_unit, tgt_unit;

  // Execute selection
  logic [NU-1:0]        ex_req;
  logic [NU*PRIO_W-1:0] ex_prio;
  logic                 ex_valid;
  logic [UNIT_W-1:0]    ex_unit;
  logic [TASK_W-1:0]    ex_task;

  always_comb begin
    for (int t = 0; t < NT; t++)
      pf_req[t] = active_q && !bound_q[t] && preds_met(task_pred_i[t*NT +: NT], started_q);
  end

  pfs_prio_pick #(.N(NT), .PRIO_W(PRIO_W)) u_pf_pick (
    .clk(clk), .rst_n(rst_n), .req_i(pf_req), .prio_i(task_prio_i),
    .valid_o(pf_valid), .idx_o(pf_task)
  );

  assign pf_type = task_type_i[pf_task*TYPE_W +: TYPE_W];

  // Lowest-index idle unit, and lowest-index idle unit already holding the type
  always_comb begin
    skip_hit  = 1'b0;
    free_hit  = 1'b0;
    skip_unit = '0;
    free_unit = '0;
    for (int u = 0; u < NU; u++) begin
      if (unit_idle(ust[u]) && !free_hit) begin
        free_hit  = 1'b1;
        free_unit = UNIT_W'(u);
      end
      if (unit_idle(ust[u]) && utok[u] && utype[u] == pf_type && !skip_hit) begin
        skip_hit  = 1'b1;
        skip_unit = UNIT_W'(u);
      end
    end
  end

  assign do_skip  = pf_valid && skip_hit;
  assign do_cfg   = pf_valid && !skip_hit && free_hit;
  assign tgt_unit = skip_hit ? skip_unit : free_unit;

  always_comb begin
    for (int u = 0; u < NU; u++) begin
      ex_req[u] = (ust[u] == U_LOADED) && preds_met(task_pred_i[utask[u]*NT +: NT], finished_q);
      ex_prio[u*PRIO_W +: PRIO_W] = task_prio_i[utask[u]*PRIO_W +: PRIO_W];
      bind_cfg[u]  = do_cfg  && (tgt_unit == UNIT_W'(u));
      bind_skip[u] = do_skip && (tgt_unit == UNIT_W'(u));
    end
  end

  pfs_prio_pick #(.N(NU), .PRIO_W(PRIO_W)) u_ex_pick (
    .clk(clk), .rst_n(rst_n), .req_i(ex_req), .prio_i(ex_prio),
    .valid_o(ex_valid), .idx_o(ex_unit)
  );

  assign ex_task = utask[ex_unit];

  always_comb begin
    for (int u = 0; u < NU; u++) launch[u] = ex_valid && (ex_unit == UNIT_W'(u));
    fin_mask = '0;
    for (int u = 0; u < NU; u++)
      if (ust[u] == U_RUN && exec_done_i[u]) fin_mask[utask[u]] = 1'b1;
  end

  for (genvar g = 0; g < NU; g++) begin : g_unit
    pfs_unit_slot #(.TASK_W(TASK_W), .TYPE_W(TYPE_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .assign_cfg_i(bind_cfg[g]), .assign_skip_i(bind_skip[g]),
      .assign_task_i(pf_task), .assign_type_i(pf_type),
      .launch_i(launch[g]),
      .cfg_done_i(cfg_done_i[g]), .exec_done_i(exec_done_i[g]),
      .state_o(ust[g]), .task_o(utask[g]), .type_o(utype[g]), .type_ok_o(utok[g])
    );
  end

  pfs_task_state #(.NT(NT), .TASK_W(TASK_W)) u_tasks (
    .clk(clk), .rst_n(rst_n), .iter_start_i(iter_start_i),
    .bind_valid_i(do_skip || do_cfg), .bind_task_i(pf_task),
    .launch_valid_i(ex_valid), .launch_task_i(ex_task),
    .fin_mask_i(fin_mask),
    .bound_o(bound_q), .started_o(started_q), .finished_o(finished_q),
    .active_o(active_q), .done_o(all_done)
  );

  assign cfg_valid_o   = do_cfg;
  assign cfg_unit_o    = free_unit;
  assign cfg_task_o    = pf_task;
  assign exe_valid_o   = ex_valid;
  assign exe_unit_o    = ex_unit;
  assign exe_task_o    = ex_task;
  assign iter_active_o = active_q;
  assign iter_done_o   = all_done;

  AST_CFG_PREDS_STARTED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid_o |-> preds_met(task_pred_i[cfg_task_o*NT +: NT], started_q)); // R3
  AST_EXE_PREDS_FINISHED: assert property (@(posedge clk) disable iff (!rst_n)
    exe_valid_o |-> preds_met(task_pred_i[exe_task_o*NT +: NT], finished_q)); // R7
  AST_IDLE_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !iter_active_o |-> (!cfg_valid_o && !exe_valid_o)); // R2
  AST_EXE_MARKS_STARTED: assert property (@(posedge clk) disable iff (!rst_n)
    exe_valid_o |=> started_q[$past(exe_task_o)]); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    iter_done_o |=> !iter_done_o); // R9
endmodule

// File: tb/cfg_prefetch_sched_tb.sv
module cfg_prefetch_sched_tb;
  localparam int NT = 6, NU = 3, TYPE_W = 2, PRIO_W = 3;
  localparam int TASK_W = $clog2(NT), UNIT_W = $clog2(NU);

  logic clk = 1'b0, rst_n = 1'b0, iter_start_i = 1'b0;
  logic [NT*NT-1:0] task_pred_i = '0;
  logic [NT*TYPE_W-1:0] task_type_i = '0;
  logic [NT*PRIO_W-1:0] task_prio_i = '0;
  logic [NU-1:0] cfg_done_i = '0, exec_done_i = '0;
  logic cfg_valid_o, exe_valid_o, iter_active_o, iter_done_o;
  logic [UNIT_W-1:0] cfg_unit_o, exe_unit_o;
  logic [TASK_W-1:0] cfg_task_o, exe_task_o;

  cfg_prefetch_sched #(.NT(NT), .NU(NU), .TYPE_W(TYPE_W), .PRIO_W(PRIO_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .iter_start_i(iter_start_i),
    .task_pred_i(task_pred_i), .task_type_i(task_type_i), .task_prio_i(task_prio_i),
    .cfg_done_i(cfg_done_i), .exec_done_i(exec_done_i),
    .cfg_valid_o(cfg_valid_o), .cfg_unit_o(cfg_unit_o), .cfg_task_o(cfg_task_o),
    .exe_valid_o(exe_valid_o), .exe_unit_o(exe_unit_o), .exe_task_o(exe_task_o),
    .iter_active_o(iter_active_o), .iter_done_o(iter_done_o)
  );

  always #10 clk = ~clk; // 50 MHz

  int n_chk = 0, n_fail = 0, cyc = 0, scen = 0;

  // Table, as the bench sees it
  logic [NT-1:0] pred [NT];
  int typ [NT];
  int pri [NT];

  // Model: unit state 0 empty, 1 configuring, 2 loaded, 3 running, 4 finished
  int m_st [NU], m_task [NU], m_type [NU], m_tim [NU];
  bit m_tok [NU];
  logic [NT-1:0] m_bnd, m_sta, m_fin;
  bit m_act;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d, graph %0d)", tag, act, exp, cyc, scen);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic load_graph(input int s);
    for (int i = 0; i < NT; i++) begin
      pred[i] = '0;
      for (int j = 0; j < i; j++)
        if (((i*3 + j*5 + s) % 4) == 0 || (j == i-1 && (s % 3) == 0)) pred[i][j] = 1'b1;
      typ[i] = (i*s + i + s) % 3;
      pri[i] = (i*3 + s*5 + i*i) % 8;
      task_pred_i[i*NT +: NT] = pred[i];
      task_type_i[i*TYPE_W +: TYPE_W] = TYPE_W'(typ[i]);
      task_prio_i[i*PRIO_W +: PRIO_W] = PRIO_W'(pri[i]);
    end
  endtask

  // One cycle: predict, compare, drive, advance the model.
  task automatic step(input bit start);
    int bt, sku, fru, exu;
    bit ecfg, edone;
    logic [NU-1:0] cd, ed;
    bt = -1; sku = -1; fru = -1; exu = -1;
    for (int t = 0; t < NT; t++)
      if (m_act && !m_bnd[t] && ((pred[t] & ~m_sta) == '0))
        if (bt < 0 || pri[t] > pri[bt]) bt = t;
    if (bt >= 0)
      for (int u = 0; u < NU; u++) begin
        if ((m_st[u] == 0 || m_st[u] == 4) && fru < 0) fru = u;
        if ((m_st[u] == 0 || m_st[u] == 4) && m_tok[u] && m_type[u] == typ[bt] && sku < 0) sku = u;
      end
    ecfg = (bt >= 0) && (sku < 0) && (fru >= 0);
    for (int u = 0; u < NU; u++)
      if (m_st[u] == 2 && ((pred[m_task[u]] & ~m_fin) == '0))
        if (exu < 0 || pri[m_task[u]] > pri[m_task[exu]]) exu = u;
    edone = m_act && (&m_fin);

    chk("R3 R4 R5 R6 R10 cfg_valid", int'(cfg_valid_o), int'(ecfg));
    if (ecfg && cfg_valid_o) begin
      chk("R5 cfg_unit", int'(cfg_unit_o), fru);
      chk("R4 cfg_task", int'(cfg_task_o), bt);
    end
    chk("R7 R8 R10 exe_valid", int'(exe_valid_o), int'(exu >= 0));
    if (exu >= 0 && exe_valid_o) begin
      chk("R7 exe_unit", int'(exe_unit_o), exu);
      chk("R7 R5 exe_task", int'(exe_task_o), m_task[exu]);
    end
    chk("R9 iter_done", int'(iter_done_o), int'(edone));
    chk("R2 iter_active", int'(iter_active_o), int'(m_act));

    // Completion events, plus stray ones on units in other states (R10)
    for (int u = 0; u < NU; u++) begin
      cd[u] = (m_st[u] == 1 && m_tim[u] == 0);
      ed[u] = (m_st[u] == 3 && m_tim[u] == 0);
      if (m_st[u] != 1 && (cyc % 5) == 1 && (cyc / 5) % NU == u) cd[u] = 1'b1;
      if (m_st[u] != 3 && (cyc % 7) == 3 && (cyc / 7) % NU == u) ed[u] = 1'b1;
    end
    iter_start_i = start;
    cfg_done_i   = cd;
    exec_done_i  = ed;
    @(posedge clk);

    for (int u = 0; u < NU; u++) begin
      if (m_st[u] == 1 && cd[u]) begin m_st[u] = 2; m_tok[u] = 1'b1; end
      else if (m_st[u] == 3 && ed[u]) begin m_st[u] = 4; m_fin[m_task[u]] = 1'b1; end
      else if ((m_st[u] == 1 || m_st[u] == 3) && m_tim[u] > 0) m_tim[u]--;
    end
    if (bt >= 0 && sku >= 0) begin
      m_st[sku] = 2; m_task[sku] = bt; m_bnd[bt] = 1'b1;
    end else if (ecfg) begin
      m_st[fru] = 1; m_task[fru] = bt; m_type[fru] = typ[bt]; m_tok[fru] = 1'b0;
      m_tim[fru] = (bt + cyc) % 4; m_bnd[bt] = 1'b1;
    end
    if (exu >= 0) begin
      m_st[exu] = 3; m_sta[m_task[exu]] = 1'b1;
      m_tim[exu] = 1 + (m_task[exu]*5 + scen) % 6;
    end
    if (edone) begin
      m_act = 1'b0; m_bnd = '0; m_sta = '0; m_fin = '0;
    end else if (start && !m_act) m_act = 1'b1;

    @(negedge clk);
    cyc++;
    if (cyc > 150000) begin
      chk("R9 watchdog", 0, 1);
      finish_run();
    end
  endtask

  initial begin
    for (int u = 0; u < NU; u++) begin
      m_st[u] = 0; m_task[u] = 0; m_type[u] = 0; m_tim[u] = 0; m_tok[u] = 1'b0;
    end
    m_bnd = '0; m_sta = '0; m_fin = '0; m_act = 1'b0;
    load_graph(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: quiet after reset
    chk("R1 cfg_valid", int'(cfg_valid_o), 0);
    chk("R1 exe_valid", int'(exe_valid_o), 0);
    chk("R1 iter_active", int'(iter_active_o), 0);
    chk("R1 iter_done", int'(iter_done_o), 0);
    // R2: no start, no commands
    repeat (4) step(1'b0);

    for (int s = 0; s < 8; s++) begin
      scen = s;
      load_graph(s);
      for (int it = 0; it < 2; it++) begin
        int guard;
        step(1'b1);
        guard = 0;
        while (m_act && guard < 500) begin
          step(guard == 4); // stray start mid-iteration (R2)
          guard++;
        end
        if (m_act) chk("R9 iteration completes", 0, 1);
        repeat (3) step(1'b0); // R2: idle between blocks
      end
    end
    finish_run();
  end
endmodule